// File: doc/BRIEF.md
# Differential Clock Stop Controller

This block gates a bank of differential clock outputs, each a true/complement pair taken from one internal reference clock. A single asynchronous, active-low stop request parks every output that is marked stoppable, while free-running outputs keep toggling. A parked output either holds true high and complement low, or releases its pair to high impedance, depending on a global stop mode. Each output also has an enable, and a low enable turns its pair off.

The internal reference is a level that toggles on every rising edge of `clk_i`, so one reference period is two `clk_i` cycles. Each lane has a small state machine that decides when to park and when to restart. Because every transition is tied to an edge of the reference in the same direction, stopping and restarting never produce a shortened high or low phase. The lanes also hold the configuration they captured while running, so writes made during a stop take effect only when the lane runs again.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_ni` is low, every `true_o` bit is 0, every `comp_o` bit is 1 and every `drive_o` bit is 0.
- R2: In every cycle, `comp_o` is the bitwise inverse of `true_o`.
- R3: The reference starts low after reset and inverts at every rising edge of `clk_i`. A running lane's `true_o` equals the reference, so it toggles on every edge.
- R4: A lane sees the stop request one edge after two register stages, which means `stop_ni` was low when sampled at edge t-2. A running lane whose captured stoppable bit is 1 parks at the first such edge where its `true_o` is high. At that edge it keeps `true_o` at 1 instead of falling. An output rises only when the reference rises and falls only when the reference falls.
- R5: A lane whose captured stoppable bit is 0 keeps toggling whatever `stop_ni` does.
- R6: When `hiz_mode_i` is 0 at capture, a parked lane has `true_o`=1, `comp_o`=0 and `drive_o` equal to its captured enable.
- R7: When `hiz_mode_i` is 1 at capture, a parked lane has `drive_o`=0.
- R8: With the default parameters, a parked lane's first falling transition after `stop_ni` rises happens at the 6th or 7th rising edge of `clk_i`, whichever of the two sees the reference fall.
- R9: A lane parked in high-impedance mode drives again at the 3rd rising edge after `stop_ni` rises, with `true_o` high. It keeps that level until it resumes toggling as in R8.
- R10: For a running lane, `drive_o` equals `enable_i` as sampled at the previous rising edge. A lane that parked with a captured enable of 0 keeps `drive_o` at 0 while it is stopped.
- R11: A lane captures the stoppable bit, the stop mode and the enable at each rising edge where it is running, including the edge at which it parks. These values stay frozen from the edge after parking until one edge after it resumes toggling.
- R12: Suppose the stop request is active at only one edge, and at that edge the lane's `true_o` is low. The lane then keeps toggling with no missing or extended phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock; the reference inverts on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| stoppable_i | input | NUM_OUT | Per-lane mask: 1 = lane may be stopped, 0 = free-running |
| enable_i | input | NUM_OUT | Per-lane enable: 0 turns the pair off |
| hiz_mode_i | input | 1 | Stop mode: 0 = park driven high, 1 = park in high impedance |
| true_o | output | NUM_OUT | True clock level per lane |
| comp_o | output | NUM_OUT | Complement clock level per lane |
| drive_o | output | NUM_OUT | Per-lane output enable for the pair driver |

## Verification
The assertions check two properties on every cycle. Each output edge must match a reference edge in the same direction, and an output leaving high impedance after a stop must come back high. Once the stop request has been quiet for long enough, every lane must toggle and its drive must follow the sampled enable. Other behaviour depends on how the stop request lines up with the reference phase, so only the bench scenarios can show it. This includes the exact restart edge, the freezing of configuration written during a stop, and a one-edge stop pulse that must not park a lane. The bench runs a behavioural model of the lanes beside the design to cover these cases.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    LANE_RUN  = 2'd0,
    LANE_PARK = 2'd1,
    LANE_WAIT = 2'd2
  } lane_state_e;

  typedef struct packed {
    logic stoppable;
    logic hiz;
    logic en;
  } lane_cfg_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_refgen.sv
module clkstop_refgen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= ~lvl_q;
  end

  assign ref_o = lvl_q;
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
#(
  parameter int unsigned RESUME_HOLD = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_i,
  input  logic      stop_req_i,
  input  lane_cfg_t cfg_i,
  output logic      true_o,
  output logic      comp_o,
  output logic      drive_o
);
  localparam int unsigned CNT_W = $clog2(RESUME_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESUME_HOLD - 1);

  lane_state_e      state_q, state_d;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  lane_cfg_t        cfg_q;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      LANE_RUN: begin
        // park on a high level so the high phase is stretched, never cut
        if (stop_req_i && cfg_q.stoppable && lvl_q) state_d = LANE_PARK;
        else                                         lvl_d   = ~ref_i;
      end
      LANE_PARK: begin
        if (!stop_req_i) begin
          state_d = LANE_WAIT;
          cnt_d   = '0;
        end
      end
      LANE_WAIT: begin
        if (stop_req_i) begin
          state_d = LANE_PARK;
        end else if (cnt_q >= CNT_LAST && ref_i) begin
          // rejoin on a reference fall
          state_d = LANE_RUN;
          lvl_d   = 1'b0;
        end else if (cnt_q != CNT_LAST) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = LANE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LANE_RUN;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
      if (state_q == LANE_RUN) cfg_q <= cfg_i;
    end
  end

  assign true_o  = lvl_q;
  assign comp_o  = ~lvl_q;
  assign drive_o = cfg_q.en && !(state_q == LANE_PARK && cfg_q.hiz);
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RESUME_HOLD = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_ni,
  input  logic [NUM_OUT-1:0] stoppable_i,
  input  logic [NUM_OUT-1:0] enable_i,
  input  logic               hiz_mode_i,
  output logic [NUM_OUT-1:0] true_o,
  output logic [NUM_OUT-1:0] comp_o,
  output logic [NUM_OUT-1:0] drive_o
);
  logic stop_sync;
  logic stop_req;
  logic ref_lvl;

  clkstop_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stop_ni),
    .q_o   (stop_sync)
  );

  assign stop_req = ~stop_sync;

  clkstop_refgen i_refgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_o (ref_lvl)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg = '{stoppable: stoppable_i[g], hiz: hiz_mode_i, en: enable_i[g]};

    clkstop_lane #(
      .RESUME_HOLD(RESUME_HOLD)
    ) i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_i     (ref_lvl),
      .stop_req_i(stop_req),
      .cfg_i     (cfg),
      .true_o    (true_o[g]),
      .comp_o    (comp_o[g]),
      .drive_o   (drive_o[g])
    );
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int unsigned NUM_OUT = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] enable_i,
  input logic [NUM_OUT-1:0] true_o,
  input logic [NUM_OUT-1:0] drive_o,
  input logic               ref_i,
  input logic               stop_req_i
);
  logic [3:0] quiet_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= '0;
      warm_q  <= '0;
    end else begin
      if (stop_req_i)            quiet_q <= '0;
      else if (quiet_q != 4'hF)  quiet_q <= quiet_q + 4'd1;
      if (warm_q != 2'd3)        warm_q  <= warm_q + 2'd1;
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    a_r4_rise_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(true_o[k]) |-> $rose(ref_i));

    a_r4_fall_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(true_o[k]) |-> $fell(ref_i));

    // R3 as well: every lane runs once the request has been quiet long enough
    a_r8_resume_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet_q >= 4'd8) |-> (true_o[k] != $past(true_o[k])));

    a_r10_enable_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet_q >= 4'd8) |-> (drive_o[k] == $past(enable_i[k])));

    a_r9_release_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3 && $rose(drive_o[k]) && $past(enable_i[k], 2)) |-> true_o[k]);
  end
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .NUM_OUT(NUM_OUT)
) i_clkstop_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .true_o    (true_o),
  .drive_o   (drive_o),
  .ref_i     (ref_lvl),
  .stop_req_i(stop_req)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
  localparam int N          = 7;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_n = 1'b1;
  logic         hiz = 1'b0;
  logic [N-1:0] stp = 7'b0001111;
  logic [N-1:0] en = '1;
  logic [N-1:0] t_o, c_o, d_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clkstop_ctrl #(.NUM_OUT(N)) i_clkstop_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .stop_ni    (stop_n),
    .stoppable_i(stp),
    .enable_i   (en),
    .hiz_mode_i (hiz),
    .true_o     (t_o),
    .comp_o     (c_o),
    .drive_o    (d_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: state 0 run, 1 parked, 2 awaiting restart
  bit m_ref;
  bit sq[$];
  int m_st[N];
  int m_cnt[N];
  bit m_lvl[N], m_sstp[N], m_shiz[N], m_sen[N];

  always @(posedge clk or negedge rst_n) begin : model
    bit req;
    bit was_run;
    if (!rst_n) begin
      m_ref = 1'b0;
      sq = '{1'b1, 1'b1};
      for (int k = 0; k < N; k++) begin
        m_st[k] = 0; m_cnt[k] = 0; m_lvl[k] = 1'b0;
        m_sstp[k] = 1'b0; m_shiz[k] = 1'b0; m_sen[k] = 1'b0;
      end
    end else begin
      req = !sq[0];
      void'(sq.pop_front());
      sq.push_back(stop_n);
      for (int k = 0; k < N; k++) begin
        was_run = (m_st[k] == 0);
        case (m_st[k])
          0: if (req && m_sstp[k] && m_lvl[k]) m_st[k] = 1; else m_lvl[k] = !m_ref;
          1: if (!req) begin m_st[k] = 2; m_cnt[k] = 0; end
          default: begin
            if (req) m_st[k] = 1;
            else if (m_cnt[k] >= 2 && m_ref) begin m_st[k] = 0; m_lvl[k] = 1'b0; end
            else m_cnt[k]++;
          end
        endcase
        if (was_run) begin m_sstp[k] = stp[k]; m_shiz[k] = hiz; m_sen[k] = en[k]; end
      end
      m_ref = !m_ref;
    end
  end

  always @(negedge clk) begin : compare
    logic [N-1:0] et, ec, ed, inv;
    if (rst_n && !done) begin
      for (int k = 0; k < N; k++) begin
        et[k] = m_lvl[k];
        ec[k] = !m_lvl[k];
        ed[k] = m_sen[k] && !(m_st[k] == 1 && m_shiz[k]);
      end
      check("R2/R4/R11 model", {t_o, c_o, d_o}, {et, ec, ed});
      inv = ~t_o;
      check("R2", c_o, inv);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin : stim
    logic [N-1:0] a, na;
    int lat;
    cyc(3);
    check("R1 true", t_o, '0);
    check("R1 comp", c_o, 7'h7F);
    check("R1 drive", d_o, '0);
    rst_n = 1'b1;
    cyc(12);

    a = t_o; cyc(1); na = ~a;
    check("R3 toggle", t_o, na);

    // driven stop
    stop_n = 1'b0;
    cyc(8);
    check("R6 true", t_o[3:0], 4'hF);
    check("R6 comp", c_o[3:0], 4'h0);
    check("R6 drive", d_o[3:0], 4'hF);
    a = t_o; cyc(1); na = ~a;
    check("R5 free-run", t_o[6:4], na[6:4]);
    check("R4 parked hold", t_o[3:0], 4'hF);
    stop_n = 1'b1;
    lat = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (lat == 0 && t_o[0] == 1'b0) begin
        lat = i;
        check("R8 lanes together", t_o[3:0], 4'h0);
      end
    end
    check("R8 latency ok", (lat == 6 || lat == 7), 1);
    cyc(3);

    // high-impedance stop
    hiz = 1'b1;
    cyc(2);
    stop_n = 1'b0;
    cyc(8);
    check("R7 parked off", d_o[3:0], 4'h0);
    check("R7 free lanes on", d_o[6:4], 3'h7);
    stop_n = 1'b1;
    cyc(2);
    check("R9 still off", d_o[3:0], 4'h0);
    cyc(1);
    check("R9 drive back", d_o[3:0], 4'hF);
    check("R9 high first", t_o[3:0], 4'hF);
    cyc(6);
    a = t_o; cyc(1); na = ~a;
    check("R9 resumed", t_o[3:0], na[3:0]);

    // writes while parked are frozen
    hiz = 1'b0;
    cyc(2);
    stop_n = 1'b0;
    cyc(8);
    stp[0] = 1'b0; hiz = 1'b1; en[0] = 1'b0;
    cyc(6);
    check("R11 lane0 parked", t_o[0], 1'b1);
    check("R11 lane0 driven", d_o[0], 1'b1);
    check("R11 lane1 mode frozen", d_o[1], 1'b1);
    stop_n = 1'b1;
    cyc(12);
    check("R10 enable after resume", d_o[1:0], 2'b10);
    stp = 7'b0001111; en = '1; hiz = 1'b0;
    cyc(3);

    // enable on a running lane
    en[1] = 1'b0;
    cyc(1);
    check("R10 running off", d_o[1], 1'b0);
    en[1] = 1'b1;
    cyc(3);

    // captured enable low during stop
    en[2] = 1'b0;
    cyc(2);
    stop_n = 1'b0;
    cyc(8);
    check("R10 parked off", d_o[2], 1'b0);
    check("R10 parked level", t_o[2], 1'b1);
    en[2] = 1'b1;
    cyc(4);
    check("R11 enable frozen", d_o[2], 1'b0);
    stop_n = 1'b1;
    cyc(12);
    check("R10 enable back", d_o[2], 1'b1);

    // stop pulse seen while lanes are low
    while (t_o[0] !== 1'b0) @(negedge clk);
    stop_n = 1'b0;
    cyc(1);
    stop_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      a = t_o; cyc(1); na = ~a;
      check("R12 no park", t_o, na);
    end

    cyc(5);
    finish_run();
  end
endmodule